// File: doc/BRIEF.md
# Serial Peripheral Slave with Buffer-Memory Ring Queues

This block is the slave end of a four-wire serial peripheral link. Every byte the host clocks in is put into a receive ring inside a 2048-byte on-chip buffer. Every byte the host clocks out is taken from a transmit ring in the same buffer. Software splits the buffer into the two rings by setting their sizes. It fills the transmit ring and drains the receive ring through a small register window. It moves the pointers that it owns, and it reads back the pointers that the hardware owns.

The serial inputs are taken to be already synchronous to the system clock. The block finds the clock edges by comparing each sample with the one before. Clock polarity, clock phase and the bit order of each direction are set in a mode register. Two level interrupts compare the fill of each ring against thresholds set by software. Two sticky status bits record a receive byte that was dropped and a transmit byte that was made up.

Top module: `spi_sram_fifo_dev`

## Requirements
- R1: After reset the registers read as follows. MODE (0x000) reads 0. SIZES (0x004) reads 0x0400_0400, which is 1024 bytes for each ring. Both pointer registers read 0. LEVEL (0x010) reads 0x03FF_0000. STATUS (0x018) reads 0. Both interrupts and MISO are low.
- R2: Each full received byte is stored at buffer offset RX write pointer, and that pointer advances by one. MODE bit 3 picks the receive bit order: 0 means the first bit is the MSB, 1 means the first bit is the LSB. RXPTR (0x008) holds the RX read pointer in bits [10:0] (software writes it) and the RX write pointer in bits [26:16] (read-only).
- R3: The RX ring holds at most size-1 bytes. A byte that arrives while the ring is full is not stored, the write pointer does not move, and STATUS bit 0 is set. STATUS bits stay set until a 1 is written to them.
- R4: Bytes are sent from the TX ring, which starts right after the RX ring in the buffer. Only bytes between the TX read pointer and the software-owned TX write pointer are sent. MODE bit 2 picks the transmit bit order, with the same coding as bit 3. TXPTR (0x00C) holds the TX write pointer in bits [10:0] and the TX read pointer in bits [26:16].
- R5: When a transmit byte is needed and the TX ring is empty, the block sends 0xFF and sets STATUS bit 1.
- R6: While CSB is high, SCK and MOSI activity changes no pointer, no status bit and no bit count.
- R7: Raising CSB in the middle of a byte throws away the partial byte. The next frame starts at bit 0.
- R8: MODE bit 0 is the clock polarity and bit 1 is the clock phase. With phase 0, data is sampled on the leading edge and the next bit is shifted out on the trailing edge. The first byte is fetched when CSB falls, and the next byte is fetched on the trailing edge that ends each byte. With phase 1, bits are shifted out on the leading edge and sampled on the trailing edge. A byte is fetched on the first leading edge of each byte.
- R9: Each ring pointer wraps to 0 after it reaches its ring size minus 1. Writing SIZES (RX size in bits [11:0], TX size in bits [27:16]) clears all four pointers.
- R10: irq_rx is high when RX fill is at least THRESH[11:0] and that threshold is nonzero. irq_tx is high when TX fill is below THRESH[27:16]. THRESH is at 0x014.
- R11: A pause of any length between bits inside a frame does not affect how the byte is put together.
- R12: Register addresses 0x800 to 0xFFF reach the buffer one byte per access, on data bits [7:0]. LEVEL gives the RX fill in bits [11:0] and the TX free space (size-1-fill) in bits [27:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sck | input | 1 | Serial clock from the host, already synchronous |
| csb | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, low while not selected |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq_rx | output | 1 | Receive fill-threshold interrupt |
| irq_tx | output | 1 | Transmit low-level interrupt |

## Verification
The bench toggles SCK for a long time while CSB is high. A design that let those edges through would move a pointer or shift a stray bit into the next byte. It ends one frame after three bits. A design that kept the partial count would store the next byte rotated. It fills the RX ring right up to size-1 with a write pointer that wraps, and then sends one more byte. A design that got this wrong would either overwrite unread data or report the wrong fill. It also tests the phase-0 prefetch, the 0xFF filler byte and a gap of several hundred cycles in the middle of a byte, each in its own mode. A wrong fetch point shows up as a shifted byte stream or a read pointer that is off by one.

// File: rtl/spid_pkg.sv
package spid_pkg;
    // Mode register layout, LSB first: polarity, phase, tx order, rx order.
    typedef struct packed {
        logic rx_lsb;
        logic tx_lsb;
        logic cpha;
        logic cpol;
    } mode_t;

    localparam int OFF_MODE   = 'h000;
    localparam int OFF_SIZES  = 'h004;
    localparam int OFF_RXPTR  = 'h008;
    localparam int OFF_TXPTR  = 'h00C;
    localparam int OFF_LEVEL  = 'h010;
    localparam int OFF_THRESH = 'h014;
    localparam int OFF_STATUS = 'h018;

    localparam logic [7:0] FILL_BYTE = 8'hFF;
endpackage

// File: rtl/spid_sck_edge.sv
module spid_sck_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic csb,
    input  logic cpol,
    input  logic cpha,
    output logic sample_p,
    output logic shift_p,
    output logic csb_fall
);
    typedef struct packed {
        logic sck;
        logic csb;
    } edge_st_t;

    edge_st_t e_d, e_q;
    logic lvl_now, lvl_prev, lead, trail;

    always_comb begin
        e_d      = '{sck: sck, csb: csb};
        lvl_now  = sck ^ cpol;
        lvl_prev = e_q.sck ^ cpol;
        lead     = lvl_now & ~lvl_prev;
        trail    = ~lvl_now & lvl_prev;
        sample_p = ~csb & (cpha ? trail : lead);
        shift_p  = ~csb & (cpha ? lead : trail);
        csb_fall = e_q.csb & ~csb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) e_q <= '{sck: 1'b0, csb: 1'b1};
        else        e_q <= e_d;
    end
endmodule

// File: rtl/spid_rx_shift.sv
module spid_rx_shift (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       csb,
    input  logic       sample_p,
    input  logic       mosi,
    input  logic       lsb_first,
    output logic       byte_vld,
    output logic [7:0] byte_out
);
    typedef struct packed {
        logic [7:0] sr;
        logic [2:0] cnt;
    } rx_st_t;

    rx_st_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        byte_vld = 1'b0;
        byte_out = lsb_first ? {mosi, r_q.sr[7:1]} : {r_q.sr[6:0], mosi};
        if (csb) begin
            r_d.cnt = '0;
        end else if (sample_p) begin
            r_d.sr   = byte_out;
            r_d.cnt  = r_q.cnt + 3'd1;
            byte_vld = (r_q.cnt == 3'd7);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R7: a deselect always leaves the bit counter at zero
    p_partial_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        csb |=> (r_q.cnt == 3'd0));
endmodule

// File: rtl/spid_tx_shift.sv
module spid_tx_shift import spid_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       csb,
    input  logic       csb_fall,
    input  logic       shift_p,
    input  logic       cpha,
    input  logic       lsb_first,
    input  logic       avail,
    input  logic [7:0] fetch_data,
    output logic       fetch,
    output logic       miso
);
    typedef struct packed {
        logic [7:0] byte_v;
        logic [2:0] cnt;
    } tx_st_t;

    tx_st_t t_d, t_q;

    always_comb begin
        t_d   = t_q;
        fetch = 1'b0;
        if (csb_fall) begin
            t_d.cnt = cpha ? 3'd7 : 3'd0;
            fetch   = ~cpha;
        end else if (shift_p) begin
            fetch   = (t_q.cnt == 3'd7);
            t_d.cnt = t_q.cnt + 3'd1;
        end
        if (fetch) t_d.byte_v = avail ? fetch_data : FILL_BYTE;
        miso = ~csb & (lsb_first ? t_q.byte_v[t_q.cnt] : t_q.byte_v[~t_q.cnt]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // R5: a fetch from an empty ring loads the filler byte
    p_fill_on_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch && !avail) |=> (t_q.byte_v == FILL_BYTE));
endmodule

// File: rtl/spid_buf_mem.sv
module spid_buf_mem #(
    parameter int DEPTH = 2048,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wa_en,
    input  logic [AW-1:0] wa_addr,
    input  logic [7:0]    wa_data,
    input  logic          wb_en,
    input  logic [AW-1:0] wb_addr,
    input  logic [7:0]    wb_data,
    input  logic [AW-1:0] ra_addr,
    output logic [7:0]    ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [7:0]    rb_data
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wa_en) mem_q[wa_addr] <= wa_data;
        if (wb_en) mem_q[wb_addr] <= wb_data;
    end

    assign ra_data = mem_q[ra_addr];
    assign rb_data = mem_q[rb_addr];
endmodule

// File: rtl/spi_sram_fifo_dev.sv
module spi_sram_fifo_dev import spid_pkg::*; #(
    parameter int BUF_BYTES   = 2048,
    parameter int ADDR_W      = 12,
    parameter int BUF_BASE    = 'h800,
    parameter int RX_SIZE_RST = 1024,
    parameter int TX_SIZE_RST = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              csb,
    input  logic              mosi,
    output logic              miso,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_rx,
    output logic              irq_tx
);
    localparam int PTR_W = $clog2(BUF_BYTES);
    localparam int SZ_W  = PTR_W + 1;

    typedef struct packed {
        mode_t             mode;
        logic [SZ_W-1:0]   rx_size;
        logic [SZ_W-1:0]   tx_size;
        logic [SZ_W-1:0]   rx_thr;
        logic [SZ_W-1:0]   tx_thr;
        logic [PTR_W-1:0]  rx_wr;
        logic [PTR_W-1:0]  rx_rd;
        logic [PTR_W-1:0]  tx_wr;
        logic [PTR_W-1:0]  tx_rd;
        logic              ovf;
        logic              udf;
    } core_st_t;

    core_st_t s_d, s_q;

    function automatic logic [SZ_W-1:0] ring_fill(logic [PTR_W-1:0] wp, logic [PTR_W-1:0] rp,
                                                  logic [SZ_W-1:0] size);
        if (wp >= rp) return {1'b0, wp} - {1'b0, rp};
        return size - {1'b0, rp} + {1'b0, wp};
    endfunction

    function automatic logic [PTR_W-1:0] ring_inc(logic [PTR_W-1:0] p, logic [SZ_W-1:0] size);
        logic [SZ_W-1:0] n;
        n = {1'b0, p} + SZ_W'(1);
        return (n >= size) ? '0 : n[PTR_W-1:0];
    endfunction

    // serial side
    logic sample_p, shift_p, csb_fall, rx_vld, tx_fetch;
    logic [7:0] rx_byte, tx_data, bus_rd_byte;

    spid_sck_edge u_edge (
        .clk(clk), .rst_n(rst_n), .sck(sck), .csb(csb),
        .cpol(s_q.mode.cpol), .cpha(s_q.mode.cpha),
        .sample_p(sample_p), .shift_p(shift_p), .csb_fall(csb_fall)
    );

    spid_rx_shift u_rx (
        .clk(clk), .rst_n(rst_n), .csb(csb), .sample_p(sample_p), .mosi(mosi),
        .lsb_first(s_q.mode.rx_lsb), .byte_vld(rx_vld), .byte_out(rx_byte)
    );

    // ring bookkeeping
    logic [SZ_W-1:0]  rx_fill, tx_fill, tx_free;
    logic             rx_full, tx_avail, in_buf, rx_store;
    logic [PTR_W-1:0] tx_addr, buf_off;

    always_comb begin
        rx_fill  = ring_fill(s_q.rx_wr, s_q.rx_rd, s_q.rx_size);
        tx_fill  = ring_fill(s_q.tx_wr, s_q.tx_rd, s_q.tx_size);
        tx_free  = s_q.tx_size - SZ_W'(1) - tx_fill;
        rx_full  = rx_fill >= (s_q.rx_size - SZ_W'(1));
        tx_avail = (tx_fill != '0);
        tx_addr  = PTR_W'(s_q.rx_size + {1'b0, s_q.tx_rd});
        in_buf   = reg_addr >= ADDR_W'(BUF_BASE);
        buf_off  = PTR_W'(reg_addr - ADDR_W'(BUF_BASE));
        rx_store = rx_vld & ~rx_full;
    end

    spid_tx_shift u_tx (
        .clk(clk), .rst_n(rst_n), .csb(csb), .csb_fall(csb_fall), .shift_p(shift_p),
        .cpha(s_q.mode.cpha), .lsb_first(s_q.mode.tx_lsb), .avail(tx_avail),
        .fetch_data(tx_data), .fetch(tx_fetch), .miso(miso)
    );

    spid_buf_mem #(.DEPTH(BUF_BYTES)) u_mem (
        .clk(clk),
        .wa_en(reg_we & in_buf), .wa_addr(buf_off), .wa_data(reg_wdata[7:0]),
        .wb_en(rx_store), .wb_addr(s_q.rx_wr), .wb_data(rx_byte),
        .ra_addr(buf_off), .ra_data(bus_rd_byte),
        .rb_addr(tx_addr), .rb_data(tx_data)
    );

    // next state: serial events first, register writes after (they win)
    always_comb begin
        s_d = s_q;
        if (rx_vld) begin
            if (rx_full) s_d.ovf   = 1'b1;
            else         s_d.rx_wr = ring_inc(s_q.rx_wr, s_q.rx_size);
        end
        if (tx_fetch) begin
            if (tx_avail) s_d.tx_rd = ring_inc(s_q.tx_rd, s_q.tx_size);
            else          s_d.udf   = 1'b1;
        end
        if (reg_we) begin
            unique case (reg_addr)
                ADDR_W'(OFF_MODE):   s_d.mode = mode_t'(reg_wdata[3:0]);
                ADDR_W'(OFF_SIZES): begin
                    s_d.rx_size = reg_wdata[SZ_W-1:0];
                    s_d.tx_size = reg_wdata[16+SZ_W-1:16];
                    s_d.rx_wr = '0; s_d.rx_rd = '0; s_d.tx_wr = '0; s_d.tx_rd = '0;
                end
                ADDR_W'(OFF_RXPTR):  s_d.rx_rd = reg_wdata[PTR_W-1:0];
                ADDR_W'(OFF_TXPTR):  s_d.tx_wr = reg_wdata[PTR_W-1:0];
                ADDR_W'(OFF_THRESH): begin
                    s_d.rx_thr = reg_wdata[SZ_W-1:0];
                    s_d.tx_thr = reg_wdata[16+SZ_W-1:16];
                end
                ADDR_W'(OFF_STATUS): begin
                    if (reg_wdata[0]) s_d.ovf = 1'b0;
                    if (reg_wdata[1]) s_d.udf = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.rx_size <= SZ_W'(RX_SIZE_RST);
            s_q.tx_size <= SZ_W'(TX_SIZE_RST);
        end else begin
            s_q <= s_d;
        end
    end

    // read mux and interrupts
    always_comb begin
        unique case (reg_addr)
            ADDR_W'(OFF_MODE):   reg_rdata = 32'(s_q.mode);
            ADDR_W'(OFF_SIZES):  reg_rdata = 32'(s_q.rx_size) | (32'(s_q.tx_size) << 16);
            ADDR_W'(OFF_RXPTR):  reg_rdata = 32'(s_q.rx_rd) | (32'(s_q.rx_wr) << 16);
            ADDR_W'(OFF_TXPTR):  reg_rdata = 32'(s_q.tx_wr) | (32'(s_q.tx_rd) << 16);
            ADDR_W'(OFF_LEVEL):  reg_rdata = 32'(rx_fill) | (32'(tx_free) << 16);
            ADDR_W'(OFF_THRESH): reg_rdata = 32'(s_q.rx_thr) | (32'(s_q.tx_thr) << 16);
            ADDR_W'(OFF_STATUS): reg_rdata = {30'b0, s_q.udf, s_q.ovf};
            default:             reg_rdata = in_buf ? {24'b0, bus_rd_byte} : 32'b0;
        endcase
        irq_rx = (s_q.rx_thr != '0) && (rx_fill >= s_q.rx_thr);
        irq_tx = tx_fill < s_q.tx_thr;
    end

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata[31:16+SZ_W], reg_wdata[15:SZ_W]};

    // R6: while deselected, no serial-side state may move
    p_idle_sck_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (csb && !reg_we) |=> ($stable(s_q.rx_wr) && $stable(s_q.tx_rd)
                              && $stable(s_q.ovf) && $stable(s_q.udf)));

    // R3: a byte arriving at a full ring does not move the write pointer
    p_drop_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_vld && rx_full && !reg_we) |=> $stable(s_q.rx_wr));

    // R3: overflow flag is sticky until software clears it
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.ovf && !(reg_we && reg_addr == ADDR_W'(OFF_STATUS))) |=> s_q.ovf);

    // R9: hardware-owned write pointer stays inside its ring
    p_rx_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.rx_size != '0) |-> ({1'b0, s_q.rx_wr} < s_q.rx_size));
endmodule

// File: tb/spi_sram_fifo_dev_tb.sv
module spi_sram_fifo_dev_tb;
    localparam int H = 4;
    localparam int BUF = 'h800;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, csb = 1'b1, mosi = 1'b0, reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic miso, irq_rx, irq_tx;
    logic [31:0] reg_rdata;

    int checks = 0, fails = 0;
    logic b_cpol = 0, b_cpha = 0, b_txlsb = 0, b_rxlsb = 0;
    logic [7:0] exp_q[$];
    logic [7:0] send_q[$];

    always #2 clk = ~clk;

    spi_sram_fifo_dev u_dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .csb(csb), .mosi(mosi), .miso(miso),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_rx(irq_rx), .irq_tx(irq_tx)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compare each byte seen on MISO with the scoreboard queue
    task automatic mon_byte(input logic [7:0] got);
        if (exp_q.size() == 0) chk("R4 unexpected miso byte", {24'b0, got}, 32'hDEAD);
        else chk("R4/R5/R8 miso byte", {24'b0, got}, {24'b0, exp_q.pop_front()});
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); reg_addr = 12'(a); reg_wdata = d; reg_we = 1'b1;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk); reg_addr = 12'(a); #1; d = reg_rdata;
    endtask

    task automatic chk_rd(input string req, input int a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic set_mode(input logic [3:0] m);
        {b_rxlsb, b_txlsb, b_cpha, b_cpol} = m;
        sck = b_cpol;
        wr('h000, {28'b0, m});
    endtask

    // driver: one byte (or a partial one) on the serial lines
    task automatic spi_bits(input logic [7:0] d, input int nbits, input int gap_bit);
        logic [7:0] got = '0;
        for (int k = 0; k < nbits; k++) begin
            if (k == gap_bit) tick(300);
            if (!b_cpha) begin
                mosi = b_rxlsb ? d[k] : d[7-k];
                tick(H);
                got[b_txlsb ? k : 7-k] = miso;
                sck = ~b_cpol; tick(H);
                sck = b_cpol;  tick(H);
            end else begin
                sck = ~b_cpol; tick(H);
                mosi = b_rxlsb ? d[k] : d[7-k];
                got[b_txlsb ? k : 7-k] = miso;
                tick(1);
                sck = b_cpol; tick(H);
            end
        end
        if (nbits == 8) mon_byte(got);
    endtask

    task automatic spi_frame(input int gap_bit);
        csb = 1'b0; tick(H);
        while (send_q.size() > 0) spi_bits(send_q.pop_front(), 8, gap_bit);
        csb = 1'b1; tick(H);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        tick(3); rst_n = 1'b1; tick(2);

        // R1 reset state
        chk_rd("R1 mode", 'h000, 32'h0);
        chk_rd("R1 sizes", 'h004, 32'h0400_0400);
        chk_rd("R1 rxptr", 'h008, 32'h0);
        chk_rd("R1 txptr", 'h00C, 32'h0);
        chk_rd("R1 level", 'h010, 32'h03FF_0000);
        chk_rd("R1 status", 'h018, 32'h0);
        chk("R1 irq/miso", {29'b0, irq_rx, irq_tx, miso}, 32'h0);

        // R12 buffer window
        wr('hFFF, 32'h6B);
        chk_rd("R12 buffer rw", 'hFFF, 32'h6B);

        // mode 0, MSB first; RX 100 bytes, TX 200 bytes
        set_mode(4'h0);
        wr('h004, 32'h00C8_0064);
        wr(BUF + 100 + 0, 32'hA5); wr(BUF + 101, 32'h3C);
        wr(BUF + 102, 32'h81);     wr(BUF + 103, 32'h5E);
        wr('h00C, 32'h4);
        exp_q.push_back(8'hA5); exp_q.push_back(8'h3C); exp_q.push_back(8'h81);
        send_q.push_back(8'h11); send_q.push_back(8'h22); send_q.push_back(8'h33);
        spi_frame(-1);
        chk_rd("R2 rx byte0", BUF + 0, 32'h11);
        chk_rd("R2 rx byte2", BUF + 2, 32'h33);
        chk_rd("R8 phase0 prefetch txptr", 'h00C, 32'h0004_0004);
        chk_rd("R12 level", 'h010, 32'h00C7_0003);
        chk_rd("R8 no underflow", 'h018, 32'h0);

        // mode 3, LSB first both ways
        set_mode(4'hF);
        wr(BUF + 104, 32'h12); wr(BUF + 105, 32'hF0);
        wr('h00C, 32'h6);
        exp_q.push_back(8'h12); exp_q.push_back(8'hF0);
        send_q.push_back(8'hC4); send_q.push_back(8'h5A);
        spi_frame(-1);
        chk_rd("R2 lsb rx byte", BUF + 3, 32'hC4);
        chk_rd("R2 lsb rx byte2", BUF + 4, 32'h5A);
        chk_rd("R8 phase1 txptr", 'h00C, 32'h0006_0006);
        chk_rd("R4 status clean", 'h018, 32'h0);

        // R5 empty TX ring -> filler
        exp_q.push_back(8'hFF); send_q.push_back(8'h77);
        spi_frame(-1);
        chk_rd("R5 underflow flag", 'h018, 32'h2);
        wr('h018, 32'h3);
        chk_rd("R3 status w1c", 'h018, 32'h0);

        // R6 SCK activity while deselected
        for (int i = 0; i < 20; i++) begin sck = ~sck; mosi = ~mosi; tick(2); end
        sck = b_cpol;
        chk_rd("R6 rxptr unchanged", 'h008, 32'h0006_0000);
        chk_rd("R6 txptr unchanged", 'h00C, 32'h0006_0006);
        chk_rd("R6 status unchanged", 'h018, 32'h0);
        exp_q.push_back(8'hFF); send_q.push_back(8'h9E);
        spi_frame(-1);
        chk_rd("R6 next byte aligned", BUF + 6, 32'h9E);
        wr('h018, 32'h3);

        // R7 partial byte discarded
        csb = 1'b0; tick(H);
        spi_bits(8'hFF, 3, -1);
        csb = 1'b1; tick(H);
        wr('h018, 32'h3);
        exp_q.push_back(8'hFF); send_q.push_back(8'h3B);
        spi_frame(-1);
        chk_rd("R7 byte after abort", BUF + 7, 32'h3B);
        chk_rd("R7 rxptr", 'h008, 32'h0008_0000);
        wr('h018, 32'h3);

        // R11 long pause inside a byte, mode 0
        set_mode(4'h0);
        wr(BUF + 106, 32'h6D); wr(BUF + 107, 32'h00);
        wr('h00C, 32'h8);
        exp_q.push_back(8'h6D); send_q.push_back(8'hB7);
        spi_frame(4);
        chk_rd("R11 gapped byte", BUF + 8, 32'hB7);
        chk_rd("R11 status", 'h018, 32'h0);

        // R9/R10/R3 small rings: RX 10, TX 8
        wr('h004, 32'h0008_000A);
        wr('h014, 32'h0003_0004);
        chk_rd("R9 size write clears ptrs", 'h008, 32'h0);
        chk("R10 irq empty", {30'b0, irq_rx, irq_tx}, 32'h1);
        for (int i = 0; i < 4; i++) wr(BUF + 10 + i, 32'h50 + i);
        wr('h00C, 32'h4);
        chk("R10 irq_tx cleared", {31'b0, irq_tx}, 32'h0);
        for (int i = 0; i < 3; i++) begin
            exp_q.push_back(8'(8'h50 + i)); send_q.push_back(8'(8'hA0 + i));
        end
        spi_frame(-1);
        chk("R10 irq after 3", {30'b0, irq_rx, irq_tx}, 32'h1);
        wr('h008, 32'h3);
        for (int i = 0; i < 4; i++) wr(BUF + 10 + 4 + i, 32'h54 + i);
        wr(BUF + 10, 32'h58);
        wr('h00C, 32'h1);
        for (int i = 0; i < 10; i++) begin
            exp_q.push_back(i < 5 ? 8'(8'h54 + i) : 8'hFF);
            send_q.push_back(8'(8'hC0 + i));
        end
        spi_frame(-1);
        chk_rd("R9 rx wrap ptr", 'h008, 32'h0002_0003);
        chk_rd("R3 full level", 'h010, 32'h0007_0009);
        chk_rd("R3 ovf+R5 udf", 'h018, 32'h3);
        chk_rd("R9 wrapped byte", BUF + 0, 32'hC7);
        chk_rd("R9 wrapped byte2", BUF + 1, 32'hC8);
        chk_rd("R3 dropped byte", BUF + 2, 32'hA2);
        chk_rd("R9 tx wrap ptr", 'h00C, 32'h0001_0001);
        chk("R10 irq_rx full", {31'b0, irq_rx}, 32'h1);
        chk("R4 all miso consumed", exp_q.size(), 32'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule